// File: doc/BRIEF.md
# Period-to-Note Range Quantizer

The block turns a 7-bit measured tone period into a 4-bit chromatic note code. A measured period rarely equals one of the twelve exact note periods, so the block snaps it to the nearest table period at or below it. A load strobe copies the period into a down-counter. The counter value, not the raw input, feeds an exact-match lookup against the twelve note periods. While nothing matches and the counter is above 21H, the counter steps down by one each clock until it lands on a table period.

Each matched code is written into an output register. The note output therefore never shows the codes of intermediate counter values, and it keeps its last note while a search runs or when an illegal period is loaded. A match flag reports that the counter currently sits on a table period.

Top module: `period_note_quantizer`

## Requirements
- R1: On a clock edge with `loadStb` high, the counter takes `periodIn`. If that value is a table period, `noteHit` is high right after that edge and `noteCode` carries the matching code after the next edge.
- R2: Codes run in chromatic order from 0 (C, the longest period) to 11 (B, the shortest). The default periods are 3E, 3A, 37, 34, 31, 2E, 2B, 29, 27, 25, 23, 21 hex for codes 0 to 11. Codes 12 to 15 never appear on `noteCode`.
- R3: When no table period matches and the counter exceeds 21H, the counter decrements by one on each clock. `noteHit` therefore goes high exactly (period − snapped period) clocks after the load edge.
- R4: A period that lies between table entries maps to the code of the largest table period below it. Any period from 3FH to 7FH maps to C (code 0).
- R5: A counter value below 22H never counts. A loaded period below 21H leaves `noteCode` unchanged and keeps `noteHit` low.
- R6: `noteCode` is written only in a cycle where the lookup reports a match, and it holds its value while a search runs.
- R7: A load in the same cycle as a pending decrement wins, and the counter takes the new period.
- R8: Reset (`rstN` low, asynchronous) clears the counter and `noteCode` to 0 and drives `noteHit` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Load the period into the counter |
| periodIn | input | 7 | Measured tone period |
| noteCode | output | 4 | Last matched note code (0 = C .. 11 = B) |
| noteHit | output | 1 | Counter currently equals a table period |

## Verification
The bench loads random periods across the whole 7-bit range. For each one it predicts the snapped code and the exact clock on which the match appears, so a counter that skips values or stops one step early would produce a wrong code or late timing. Directed cases cover the boundary values. At 21H a design that counts would roll past B. At 20H and 00H a design that counts would wrap around and emit C. At 3FH and 7FH a wrong range test would never reach C. A mid-search check catches an output register that shows intermediate codes, and a load issued during a search catches a design in which decrement beats load.

// File: rtl/pnq_pkg.sv
package pnq_pkg;
  localparam int PERIOD_W = 7;
  localparam int CODE_W   = 4;
  localparam int NOTES    = 12;

  // entry i sits at bits [i*PERIOD_W +: PERIOD_W]; index 0 = C
  localparam logic [NOTES*PERIOD_W-1:0] DEFAULT_TABLE = {
    7'h21, 7'h23, 7'h25, 7'h27, 7'h29, 7'h2B,
    7'h2E, 7'h31, 7'h34, 7'h37, 7'h3A, 7'h3E
  };

  typedef struct packed {
    logic load;
    logic dec;
  } ctrl_t;
endpackage

// File: rtl/pnq_lookup.sv
module pnq_lookup
  import pnq_pkg::*;
#(
  parameter int PW = PERIOD_W,
  parameter int CW = CODE_W,
  parameter int NN = NOTES,
  parameter logic [NN*PW-1:0] TABLE = DEFAULT_TABLE
) (
  input  logic [PW-1:0] cntVal,
  output logic          hit,
  output logic [CW-1:0] hitCode
);
  logic [NN-1:0] eqVec;

  for (genvar i = 0; i < NN; i++) begin : gCmp
    assign eqVec[i] = (cntVal == TABLE[i*PW +: PW]);
  end

  always_comb begin
    hitCode = '0;
    for (int i = NN - 1; i >= 0; i--) begin
      if (eqVec[i]) hitCode = CW'(i);
    end
  end

  assign hit = |eqVec;
endmodule

// File: rtl/pnq_control.sv
module pnq_control
  import pnq_pkg::*;
#(
  parameter int PW = PERIOD_W
) (
  input  logic          loadStb,
  input  logic          hit,
  input  logic [PW-1:0] cntVal,
  output ctrl_t         ctrl
);
  logic aboveFloor;

  // above 21H: bit 6, or bit 5 with any of bits 4..1
  assign aboveFloor = cntVal[PW-1] | (cntVal[PW-2] & (|cntVal[PW-3:1]));

  always_comb begin
    ctrl.load = loadStb;
    ctrl.dec  = !loadStb && !hit && aboveFloor;
  end
endmodule

// File: rtl/pnq_datapath.sv
module pnq_datapath
  import pnq_pkg::*;
#(
  parameter int PW = PERIOD_W,
  parameter int CW = CODE_W,
  parameter int NN = NOTES,
  parameter logic [NN*PW-1:0] TABLE = DEFAULT_TABLE
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [PW-1:0] periodIn,
  output logic [PW-1:0] cntVal,
  output logic          hit,
  output logic [CW-1:0] noteReg
);
  logic [CW-1:0] hitCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntVal <= '0;
    else if (ctrl.load) cntVal <= periodIn;
    else if (ctrl.dec)  cntVal <= cntVal - 1'b1;
  end

  pnq_lookup #(.PW(PW), .CW(CW), .NN(NN), .TABLE(TABLE)) uLookup (
    .cntVal (cntVal),
    .hit    (hit),
    .hitCode(hitCode)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    noteReg <= '0;
    else if (hit) noteReg <= hitCode;
  end

  AST_HIT_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> noteReg == $past(hitCode)); // R6
  AST_HOLD_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> $stable(noteReg)); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    noteReg < CW'(NN)); // R2
endmodule

// File: rtl/period_note_quantizer.sv
module period_note_quantizer
  import pnq_pkg::*;
#(
  parameter int PW = PERIOD_W,
  parameter int CW = CODE_W,
  parameter int NN = NOTES,
  parameter logic [NN*PW-1:0] TABLE = DEFAULT_TABLE
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadStb,
  input  logic [PW-1:0] periodIn,
  output logic [CW-1:0] noteCode,
  output logic          noteHit
);
  localparam logic [PW-1:0] FLOOR_P = PW'(8'h22);

  ctrl_t         ctrl;
  logic [PW-1:0] cntVal;
  logic          hit;

  pnq_control #(.PW(PW)) uCtrl (
    .loadStb(loadStb),
    .hit    (hit),
    .cntVal (cntVal),
    .ctrl   (ctrl)
  );

  pnq_datapath #(.PW(PW), .CW(CW), .NN(NN), .TABLE(TABLE)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .periodIn(periodIn),
    .cntVal  (cntVal),
    .hit     (hit),
    .noteReg (noteCode)
  );

  assign noteHit = hit;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> cntVal == $past(periodIn)); // R7
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !noteHit && cntVal >= FLOOR_P) |=> cntVal == $past(cntVal) - 1'b1); // R3
  AST_NO_COUNT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && cntVal < FLOOR_P) |=> $stable(cntVal)); // R5
  AST_MATCH_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && noteHit) |=> $stable(cntVal) && noteHit); // R3
endmodule

// File: tb/sim_period_note_quantizer.sv
module sim_period_note_quantizer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStb = 1'b0;
  logic [6:0] periodIn = '0;
  logic [3:0] noteCode;
  logic       noteHit;

  int nChecks = 0;
  int nFails  = 0;
  int prevNote = 0;
  bit done = 1'b0;

  localparam int TBL [12] = '{'h3E, 'h3A, 'h37, 'h34, 'h31, 'h2E,
                              'h2B, 'h29, 'h27, 'h25, 'h23, 'h21};

  always #5 clk = ~clk;

  period_note_quantizer u0 (
    .clk(clk), .rstN(rstN), .loadStb(loadStb),
    .periodIn(periodIn), .noteCode(noteCode), .noteHit(noteHit)
  );

  function automatic int snapIdx(int p);
    for (int i = 0; i < 12; i++) if (TBL[i] <= p) return i;
    return -1;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive load; returns at the negedge just after the load edge
  task automatic doLoad(int p);
    @(negedge clk);
    loadStb = 1'b1;
    periodIn = 7'(p);
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic runOne(int p, string req);
    int idx;
    int steps;
    idx = snapIdx(p);
    doLoad(p);
    if (idx < 0) begin
      repeat (4) @(negedge clk);
      check({req, " R5 note held"}, noteCode, prevNote);
      check({req, " R5 hit low"}, noteHit, 0);
      return;
    end
    steps = p - TBL[idx];
    if (steps > 0) begin
      check({req, " R3 no early hit"}, noteHit, 0);
      check({req, " R6 held at start"}, noteCode, prevNote);
      repeat (steps) @(negedge clk);
    end
    check({req, " R3 hit timing"}, noteHit, 1);
    check({req, " R6 not yet written"}, noteCode, prevNote);
    @(negedge clk);
    check({req, " R4 snapped code"}, noteCode, idx);
    prevNote = idx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R8 reset code", noteCode, 0);
    check("R8 reset hit", noteHit, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 hit low after release", noteHit, 0);

    // R1 / R2: every exact table period matches directly
    for (int i = 11; i >= 0; i--) runOne(TBL[i], "R1 R2 exact");
    runOne('h21, "R5 floor 21H");
    runOne('h20, "R5 illegal 20H");
    runOne('h00, "R5 illegal 00H");
    runOne('h3F, "R4 3FH to C");
    runOne('h30, "R4 between");
    runOne('h7F, "R4 7FH to C");
    runOne('h22, "R4 22H to B");

    // R7: load during an active search
    doLoad('h3C);
    check("R7 searching", noteHit, 0);
    loadStb = 1'b1;
    periodIn = 7'h21;
    @(negedge clk);
    loadStb = 1'b0;
    check("R7 load won hit", noteHit, 1);
    @(negedge clk);
    check("R7 load won code", noteCode, 11);
    prevNote = 11;

    for (int n = 0; n < 60; n++) runOne(int'($urandom() % 128), "R3 R4 random");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule